// File: doc/BRIEF.md
# PCI Memory-Write Burst Initiator

This block is the bus-master half of a PCI write path. A local client asks for one burst by pulsing `start` with a start address and a word count. The engine then drives one address phase carrying the memory-write command, followed by as many data phases as the count asks for. It pulls words from a valid/ready stream into a single holding register, and each word carries its own byte enables. While no word is held, IRDY stays deasserted, which is the initiator's own wait state. The engine also waits out a target that holds TRDY deasserted. FRAME is released on the clock that presents the final word with IRDY asserted.

Three active-low side strobes help bridge the burst onto a simpler local bus. `las_n` marks the address clock. `lds_n` marks each clock in which a word completes. `blast_n` marks the final word. They move only while the engine owns the bus. If no target claims the cycle with DEVSEL in time, the engine ends the cycle as a master abort and reports it on the local side. Each burst closes with a one-clock `done` pulse, the abort flag and the number of words moved.

Top module: `pci_burst_wr_master`

## Requirements
- R1: After reset the engine is idle: `mst_active`, `busy`, `done`, `ad_oe` low; `frame_n`, `irdy_n`, `las_n`, `lds_n`, `blast_n` high.
- R2: The clock after `start` is accepted is the address phase: `frame_n`=0, `irdy_n`=1, `ad_oe`=1, `ad_o`=start address, `cbe_n_o`=4'b0111 (memory write), `las_n`=0 for this one clock only.
- R3: In every data-phase clock where a word is held, `irdy_n`=0, `ad_o` is that word and `cbe_n_o` is the bitwise inverse of its local `wr_be` (local enables active high, bus enables active low). Words are presented in stream order, starting on the clock after the address phase.
- R4: A word completes only on an edge where `irdy_n`, `trdy_n` and `devsel_n` are all low. `lds_n` is low in exactly those clocks. The next word is presented on the following clock, and `ad_o`/`cbe_n_o` hold steady until then.
- R5: While no local word is held in a data phase, `irdy_n` stays high and `frame_n` stays low.
- R6: `frame_n` goes high in the same clock that `irdy_n` is asserted for the final word. `blast_n` is low in exactly those clocks, and both remain until that word completes.
- R7: On the clock after the final word completes, `frame_n` and `irdy_n` are high, `ad_oe`=0, and `done` pulses for one clock with `aborted`=0 and `words_done` equal to the count.
- R8: A count of 1 gives a single data phase whose first IRDY clock already has `frame_n` high.
- R9: If `devsel_n` is sampled high on 5 consecutive edges after the address phase, the next clock shows `frame_n`=1 with `irdy_n`=0. The clock after that releases the bus and pulses `done` with `aborted`=1 and `words_done`=0.
- R10: The three side strobes and FRAME/IRDY are inactive, and `ad_oe` is low, whenever `mst_active` is low.
- R11: `start` is ignored while `busy` is high or when the count is 0.
- R12: `wr_ready` is high exactly when the engine is in the address phase or a data phase, the holding register is empty or completing, and fewer than count words have been taken. Each word is taken once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request one burst |
| start_addr | input | 32 | Burst start address |
| start_count | input | CNT_W | Number of words in the burst |
| busy | output | 1 | A burst is in progress |
| wr_valid | input | 1 | Local word available |
| wr_ready | output | 1 | Engine takes the local word this clock |
| wr_data | input | 32 | Local data word |
| wr_be | input | 4 | Local byte enables, active high |
| done | output | 1 | One-clock end-of-burst pulse |
| aborted | output | 1 | Last burst ended in master abort |
| words_done | output | CNT_W | Words completed in the last burst |
| mst_active | output | 1 | Engine owns the bus and drives FRAME/IRDY |
| frame_n | output | 1 | FRAME, active low |
| irdy_n | output | 1 | IRDY, active low |
| ad_oe | output | 1 | Drive enable for AD and C/BE |
| ad_o | output | 32 | AD output value |
| cbe_n_o | output | 4 | C/BE output value |
| trdy_n | input | 1 | TRDY from target, active low |
| devsel_n | input | 1 | DEVSEL from target, active low |
| las_n | output | 1 | Side address strobe, active low |
| lds_n | output | 1 | Side data strobe, active low |
| blast_n | output | 1 | Side burst-last strobe, active low |

## Verification
Two pairs of events can land on the same clock. In the first, a word completes on the bus while the next local word is loaded into the single holding register. A local stream that is always valid, against a target that is ready every clock, forces this every cycle. The bench judges it by predicting `wr_ready` from its own completed and taken counts and by checking that the following clock shows the next word. In the second, the final word's completion coincides with the burst-last and data strobes. The bench sweeps burst lengths 1 to 4 against several TRDY and local-valid patterns, so the last word meets a stalled or a ready target, and it checks the bus-release clock right after.

// File: rtl/pci_burst_wr_master.sv
module pci_burst_wr_master #(
  parameter int CNT_W      = 8,
  parameter int ABORT_CLKS = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [31:0]      start_addr,
  input  logic [CNT_W-1:0] start_count,
  output logic             busy,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [31:0]      wr_data,
  input  logic [3:0]       wr_be,
  output logic             done,
  output logic             aborted,
  output logic [CNT_W-1:0] words_done,
  output logic             mst_active,
  output logic             frame_n,
  output logic             irdy_n,
  output logic             ad_oe,
  output logic [31:0]      ad_o,
  output logic [3:0]       cbe_n_o,
  input  logic             trdy_n,
  input  logic             devsel_n,
  output logic             las_n,
  output logic             lds_n,
  output logic             blast_n
);
  localparam int TMO_W = $clog2(ABORT_CLKS + 1);
  localparam logic [3:0] CMD_MEM_WR = 4'b0111;

  typedef enum logic [1:0] {S_IDLE, S_ADDR, S_DATA, S_ABORT} st_t;

  st_t              st;
  logic [31:0]      addr_q, data_q;
  logic [3:0]       be_q;
  logic             have_q, seen_q, done_q, abort_q;
  logic [CNT_W-1:0] total_q, fetched_q, words_q;
  logic [TMO_W-1:0] tmo_q;

  logic in_data, last, xfer, timeout, need, take;

  assign in_data = (st == S_DATA);
  assign last    = (words_q + 1'b1 == total_q);
  assign xfer    = in_data && have_q && !trdy_n && !devsel_n;
  assign timeout = in_data && !seen_q && devsel_n && (tmo_q == TMO_W'(ABORT_CLKS - 1));
  assign need    = (fetched_q != total_q);
  assign wr_ready = ((st == S_ADDR) || (in_data && !timeout)) && (!have_q || xfer) && need;
  assign take    = wr_ready && wr_valid;

  assign mst_active = (st != S_IDLE);
  assign busy       = mst_active;
  assign ad_oe      = mst_active;
  assign frame_n    = !((st == S_ADDR) || (in_data && !(have_q && last)));
  assign irdy_n     = !((in_data && have_q) || (st == S_ABORT));
  assign ad_o       = (st == S_ADDR) ? addr_q : (st == S_IDLE) ? 32'h0 : data_q;
  assign cbe_n_o    = (st == S_ADDR) ? CMD_MEM_WR : (st == S_IDLE) ? 4'hF : ~be_q;
  assign las_n      = !(st == S_ADDR);
  assign lds_n      = !xfer;
  assign blast_n    = !(in_data && have_q && last);

  assign done       = done_q;
  assign aborted    = abort_q;
  assign words_done = words_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      addr_q    <= '0;
      data_q    <= '0;
      be_q      <= '0;
      have_q    <= 1'b0;
      seen_q    <= 1'b0;
      done_q    <= 1'b0;
      abort_q   <= 1'b0;
      total_q   <= '0;
      fetched_q <= '0;
      words_q   <= '0;
      tmo_q     <= '0;
    end else begin
      done_q <= 1'b0;
      if (take) begin
        data_q    <= wr_data;
        be_q      <= wr_be;
        have_q    <= 1'b1;
        fetched_q <= fetched_q + 1'b1;
      end else if (xfer) begin
        have_q <= 1'b0;
      end
      case (st)
        S_IDLE: begin
          if (start && (start_count != '0)) begin
            st        <= S_ADDR;
            addr_q    <= start_addr;
            total_q   <= start_count;
            fetched_q <= '0;
            words_q   <= '0;
            have_q    <= 1'b0;
            seen_q    <= 1'b0;
            tmo_q     <= '0;
            abort_q   <= 1'b0;
          end
        end
        S_ADDR: st <= S_DATA;
        S_DATA: begin
          if (!devsel_n) seen_q <= 1'b1;
          else if (!seen_q) tmo_q <= tmo_q + 1'b1;
          if (timeout) st <= S_ABORT;
          if (xfer) begin
            words_q <= words_q + 1'b1;
            if (last) begin
              st     <= S_IDLE;
              done_q <= 1'b1;
            end
          end
        end
        S_ABORT: begin
          st      <= S_IDLE;
          done_q  <= 1'b1;
          abort_q <= 1'b1;
          have_q  <= 1'b0;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pci_burst_wr_master_chk.sv
module pci_burst_wr_master_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        mst_active,
  input logic        frame_n,
  input logic        irdy_n,
  input logic        ad_oe,
  input logic [31:0] ad_o,
  input logic [3:0]  cbe_n_o,
  input logic        trdy_n,
  input logic        devsel_n,
  input logic        las_n,
  input logic        lds_n,
  input logic        blast_n,
  input logic        done,
  input logic        aborted
);
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !mst_active |-> (las_n && lds_n && blast_n && frame_n && irdy_n && !ad_oe));

  p_addr_once_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !las_n |=> las_n);

  p_addr_cmd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !las_n |-> (cbe_n_o == 4'b0111 && !frame_n && irdy_n && ad_oe));

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!irdy_n && (trdy_n || devsel_n) && !(frame_n && blast_n))
      |=> ($stable(ad_o) && $stable(cbe_n_o)));

  p_last_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!blast_n && lds_n && !devsel_n) |=> (!blast_n && !irdy_n && frame_n));

  p_end_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!lds_n && !blast_n) |=> (frame_n && irdy_n && !ad_oe && done && !aborted));

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_abort_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mst_active && frame_n && !irdy_n && blast_n) |=> (!mst_active && done && aborted));
endmodule

bind pci_burst_wr_master pci_burst_wr_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mst_active(mst_active), .frame_n(frame_n),
  .irdy_n(irdy_n), .ad_oe(ad_oe), .ad_o(ad_o), .cbe_n_o(cbe_n_o),
  .trdy_n(trdy_n), .devsel_n(devsel_n), .las_n(las_n), .lds_n(lds_n),
  .blast_n(blast_n), .done(done), .aborted(aborted)
);

// File: tb/sim_pci_burst_wr_master.sv
`timescale 1ns/1ps
module sim_pci_burst_wr_master;
  localparam int AB = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] start_addr = '0;
  logic [7:0]  start_count = '0;
  logic        busy, wr_ready, done, aborted, mst_active;
  logic        frame_n, irdy_n, ad_oe, las_n, lds_n, blast_n;
  logic        wr_valid = 1'b0;
  logic [31:0] wr_data = '0;
  logic [3:0]  wr_be = '0;
  logic [7:0]  words_done;
  logic [31:0] ad_o;
  logic [3:0]  cbe_n_o;
  logic        trdy_n = 1'b1;
  logic        devsel_n = 1'b1;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  pci_burst_wr_master u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .start_count(start_count), .busy(busy), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_data(wr_data), .wr_be(wr_be), .done(done),
    .aborted(aborted), .words_done(words_done), .mst_active(mst_active),
    .frame_n(frame_n), .irdy_n(irdy_n), .ad_oe(ad_oe), .ad_o(ad_o),
    .cbe_n_o(cbe_n_o), .trdy_n(trdy_n), .devsel_n(devsel_n),
    .las_n(las_n), .lds_n(lds_n), .blast_n(blast_n)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] wdat(input int b, input int k);
    return 32'hC3A5_0000 + 32'(b * 256) + 32'(k);
  endfunction

  function automatic logic [3:0] wbe(input int k);
    return 4'((k * 5 + 3) % 16);
  endfunction

  task automatic run_burst(input int b, input int n, input int dl, input int tm,
                           input int vm, input bit abrt, input bit hold);
    int c = 0;
    int k = 0;
    int fetched = 0;
    bit fin = 0;
    bit irdy_on, xfer, hs, exp_rdy;
    logic [31:0] addr;
    addr = 32'h1000_0000 + 32'(b * 16);
    @(negedge clk);
    start = 1'b1; start_addr = addr; start_count = 8'(n);
    @(negedge clk);
    start = hold;
    if (hold) begin start_addr = 32'hDEAD_0000; start_count = 8'd9; end
    while (!fin) begin
      devsel_n = !(!abrt && c >= dl + 1);
      trdy_n   = !(!devsel_n && (c % (tm + 1)) == 0);
      wr_valid = (vm == 0) ? 1'b1 : (vm == 1) ? (c % 2 == 1) : (c % 3 == 0);
      wr_data  = wdat(b, fetched);
      wr_be    = wbe(fetched);
      #1;
      irdy_on = (c >= 1) && (fetched > k);
      xfer = irdy_on && !trdy_n && !devsel_n;
      if (c == 0) begin
        chk(!frame_n && irdy_n && ad_oe, "R2", "addr frame/irdy/oe", {frame_n, irdy_n, ad_oe}, 3'b011);
        chk(ad_o == addr, "R2", "addr value", ad_o, addr);
        chk(cbe_n_o == 4'b0111, "R2", "command", cbe_n_o, 4'b0111);
        chk(!las_n, "R2", "las_n", las_n, 0);
        chk(wr_ready == (fetched < n), "R12", "ready in addr", wr_ready, fetched < n);
      end else if (abrt && c == AB + 1) begin
        chk(frame_n && !irdy_n && mst_active, "R9", "abort frame/irdy", {frame_n, irdy_n}, 2'b10);
        chk(wr_ready == 1'b0, "R12", "no take in abort", wr_ready, 0);
      end else if (abrt && c == AB + 2) begin
        chk(done && aborted, "R9", "abort done", {done, aborted}, 2'b11);
        chk(words_done == 8'd0, "R9", "abort count", words_done, 0);
        chk(!mst_active && !ad_oe && frame_n && irdy_n, "R9", "abort release", {mst_active, ad_oe}, 0);
        start = 1'b0;
        fin = 1;
      end else if (!abrt && k == n) begin
        chk(done && !aborted, "R7", "done/aborted", {done, aborted}, 2'b10);
        chk(words_done == 8'(n), "R7", "words_done", words_done, n);
        chk(frame_n && irdy_n && !ad_oe, "R7", "release", {frame_n, irdy_n, ad_oe}, 3'b110);
        chk(!mst_active && las_n && lds_n && blast_n, "R10", "strobes idle", {las_n, lds_n, blast_n}, 3'b111);
        if (hold) chk(!busy, "R11", "held start not taken yet", busy, 0);
        start = 1'b0;
        fin = 1;
      end else begin
        exp_rdy = ((fetched <= k) || xfer) && (fetched < n);
        chk(irdy_n == !irdy_on, (irdy_on ? "R3" : "R5"), "irdy_n", irdy_n, !irdy_on);
        if (irdy_on) begin
          chk(ad_o == wdat(b, k), "R3", "data word", ad_o, wdat(b, k));
          chk(cbe_n_o == ~wbe(k), "R3", "byte enables", cbe_n_o, ~wbe(k));
        end
        chk(frame_n == (irdy_on && k == n - 1), (n == 1 ? "R8" : "R6"), "frame_n", frame_n, irdy_on && k == n - 1);
        chk(blast_n == !(irdy_on && k == n - 1), "R6", "blast_n", blast_n, !(irdy_on && k == n - 1));
        chk(lds_n == !xfer, "R4", "lds_n", lds_n, !xfer);
        chk(las_n, "R2", "las_n after addr", las_n, 1);
        chk(wr_ready == exp_rdy, "R12", "wr_ready", wr_ready, exp_rdy);
      end
      hs = wr_valid && wr_ready;
      if (c > 200) begin
        chk(0, "R4", "burst never ended", c, 0);
        fin = 1;
      end
      @(negedge clk);
      if (xfer) k++;
      if (hs) fetched++;
      c++;
    end
    start = 1'b0; devsel_n = 1'b1; trdy_n = 1'b1; wr_valid = 1'b0;
    #1;
    chk(!done, "R7", "done one clock", done, 0);
    chk(!mst_active, "R11", "no restart", mst_active, 0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_bad++;
        n_chk++;
        $display("FAIL R1 watchdog expired: actual %0d expected below 150000", cyc);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
      end
    end
  end

  initial begin
    int b = 0;
    repeat (3) @(negedge clk);
    #1;
    chk(!mst_active && !busy && !done && !ad_oe, "R1", "reset idle", {mst_active, busy, done, ad_oe}, 0);
    chk(frame_n && irdy_n && las_n && lds_n && blast_n, "R1", "reset strobes",
        {frame_n, irdy_n, las_n, lds_n, blast_n}, 5'h1F);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk(!mst_active && frame_n && irdy_n && !ad_oe, "R1", "after reset", {mst_active, frame_n, irdy_n}, 3'b011);

    @(negedge clk);
    start = 1'b1; start_addr = 32'h2222_0000; start_count = 8'd0;
    @(negedge clk);
    start = 1'b0;
    repeat (2) @(negedge clk);
    #1;
    chk(!mst_active && las_n && frame_n, "R11", "zero count ignored", mst_active, 0);

    for (int n = 1; n <= 4; n++)
      for (int dl = 0; dl <= 2; dl++)
        for (int tm = 0; tm <= 2; tm++)
          for (int vm = 0; vm <= 2; vm++) begin
            run_burst(b, n, dl, tm, vm, 1'b0, 1'b0);
            b++;
          end
    run_burst(b, 2, 4, 0, 0, 1'b0, 1'b0); b++;
    run_burst(b, 3, 0, 0, 0, 1'b1, 1'b0); b++;
    run_burst(b, 1, 0, 0, 0, 1'b1, 1'b0); b++;
    run_burst(b, 3, 1, 1, 1, 1'b0, 1'b1); b++;
    run_burst(b, 4, 4, 2, 2, 1'b0, 1'b0); b++;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule